// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a two-part logical address (a segment number plus an offset inside that segment) into a physical address. The segment descriptors live in ordinary memory as a table. A table-base input gives the word address of that table. A table-length input gives how many segments are in use.

For each accepted request the unit first bounds the segment number against the table length. It then fetches the two-word descriptor through a simple request/response read port and checks validity, the offset limit and the access privilege. It returns either base plus offset or a fault code.

The unit keeps the last descriptor it fetched, tagged with its segment number and table base. A repeat of the same segment under the same table skips both memory reads.

Top module: `seg_xlate`

The control is one finite-state machine with these states:
- `ST_IDLE`: ready for a request.
- `ST_RD_BASE`: waiting for the base word.
- `ST_RD_LIM`: waiting for the limit/flag word.
- `ST_CHECK`: applying the descriptor checks.
- `ST_RESP`: presenting the result for one cycle.

Its transitions are:
- `ST_IDLE`→`ST_RESP` when the segment number is out of range.
- `ST_IDLE`→`ST_CHECK` when the remembered descriptor matches.
- `ST_IDLE`→`ST_RD_BASE` on any other accepted request.
- `ST_RD_BASE`→`ST_RD_LIM` on read data.
- `ST_RD_LIM`→`ST_CHECK` on read data.
- `ST_CHECK`→`ST_RESP` always.
- `ST_RESP`→`ST_IDLE` always.

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0 and `mem_req` is 0.
- R2: A request whose segment number is not less than `tbl_len` completes with fault 1 and physical address 0. Its `done` pulse comes in the cycle right after acceptance, and it issues no memory read.
- R3: On a descriptor fetch the unit reads word address `tbl_base + 2*seg` (the base word, low PA_W bits) and then `tbl_base + 2*seg + 1` (the limit word). `mem_addr` is held stable while `mem_req` waits for `mem_rvalid`.
- R4: A descriptor whose valid flag (limit word bit DATA_W-1) is 0 gives fault 2.
- R5: An offset greater than or equal to the limit (limit word bits OFF_W:0) gives fault 3. An offset of limit-1 is legal.
- R6: The access code is 0 for read, 1 for write, 2 for execute and 3 for reserved. It is refused with fault 4 unless the matching flag is set: read at bit DATA_W-2, write at bit DATA_W-3, execute at bit DATA_W-4. Code 3 is always refused.
- R7: When several checks fail, the lowest fault code wins, in the order range (1), valid (2), limit (3), privilege (4).
- R8: A legal access gives fault 0 and `pa` = base + offset modulo 2^PA_W. Every faulting result reports `pa` = 0.
- R9: A request for the same segment number under the same `tbl_base` as the last fetched descriptor issues no memory read, and its `done` pulse comes two cycles after acceptance. A different `tbl_base` forces a new fetch.
- R10: `done` is a one-cycle pulse. `req_ready` is 0 from acceptance until after `done`, and requests presented meanwhile are ignored.
- R11: With `tbl_len` = 0 every request gets fault 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base | input | MA_W | Word address of segment table |
| tbl_len | input | SEG_W+1 | Number of segments in use |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within segment |
| req_acc | input | 2 | Access type (0 read, 1 write, 2 execute, 3 reserved) |
| done | output | 1 | Result valid pulse |
| pa | output | PA_W | Physical address (0 on fault) |
| fault | output | 3 | Fault code 0..4 |
| mem_req | output | 1 | Memory read request, held until response |
| mem_addr | output | MA_W | Memory word address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The bench builds the unit with SEG_W=4, OFF_W=8, PA_W=16, MA_W=12 and DATA_W=32. Sixteen segment numbers with a table length of six let out-of-range numbers both just above the length and at the top of the field be exercised. A 16-bit physical space lets base plus offset wrap past the top. A 9-bit limit field reaches the full-segment limit of 256, so offset 255 can be checked as legal. Memory latency is varied between one and three cycles, and two table copies at different bases exercise the tag of the remembered descriptor.

// File: rtl/seg_pkg.sv
package seg_pkg;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_RANGE   = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_LIMIT   = 3'd3,
        FLT_PRIV    = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_BASE,
        ST_RD_LIM,
        ST_CHECK,
        ST_RESP
    } state_e;

    typedef struct packed {
        logic valid;
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

endpackage

// File: rtl/seg_entry_cache.sv
module seg_entry_cache
    import seg_pkg::*;
#(
    parameter int SEG_W = 4,
    parameter int PA_W  = 20,
    parameter int LIM_W = 11,
    parameter int MA_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEG_W-1:0] load_seg,
    input  logic [MA_W-1:0]  load_tbl,
    input  logic [PA_W-1:0]  load_base,
    input  logic [LIM_W-1:0] load_limit,
    input  perm_t            load_perm,
    input  logic [SEG_W-1:0] look_seg,
    input  logic [MA_W-1:0]  look_tbl,
    output logic             hit,
    output logic [PA_W-1:0]  base,
    output logic [LIM_W-1:0] limit,
    output perm_t            perm
);

    logic             vld_q;
    logic [SEG_W-1:0] seg_q;
    logic [MA_W-1:0]  tbl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            seg_q <= '0;
            tbl_q <= '0;
            base  <= '0;
            limit <= '0;
            perm  <= '0;
        end else if (load) begin
            vld_q <= 1'b1;
            seg_q <= load_seg;
            tbl_q <= load_tbl;
            base  <= load_base;
            limit <= load_limit;
            perm  <= load_perm;
        end
    end

    assign hit = vld_q && (seg_q == look_seg) && (tbl_q == look_tbl);

endmodule

// File: rtl/seg_checker.sv
module seg_checker
    import seg_pkg::*;
#(
    parameter int OFF_W = 10,
    parameter int PA_W  = 20,
    parameter int LIM_W = OFF_W + 1
) (
    input  logic [PA_W-1:0]  base,
    input  logic [LIM_W-1:0] limit,
    input  perm_t            perm,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       acc,
    output logic [2:0]       fault,
    output logic [PA_W-1:0]  pa
);

    logic allowed;

    always_comb begin
        unique case (acc_e'(acc))
            ACC_READ:  allowed = perm.rd;
            ACC_WRITE: allowed = perm.wr;
            ACC_EXEC:  allowed = perm.ex;
            default:   allowed = 1'b0;
        endcase
    end

    always_comb begin
        if (!perm.valid)
            fault = FLT_INVALID;
        else if ({1'b0, off} >= limit)
            fault = FLT_LIMIT;
        else if (!allowed)
            fault = FLT_PRIV;
        else
            fault = FLT_NONE;
    end

    assign pa = base + PA_W'(off);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int OFF_W  = 10,
    parameter int PA_W   = 20,
    parameter int MA_W   = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MA_W-1:0]   tbl_base,
    input  logic [SEG_W:0]    tbl_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              done,
    output logic [PA_W-1:0]   pa,
    output logic [2:0]        fault,
    output logic              mem_req,
    output logic [MA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int LIM_W    = OFF_W + 1;
    localparam int FLAG_MSB = DATA_W - 1;

    state_e state_q, state_d;

    logic [SEG_W-1:0] seg_q;
    logic [OFF_W-1:0] off_q;
    logic [1:0]       acc_q;
    logic [MA_W-1:0]  tbl_q;
    logic [PA_W-1:0]  base_q;
    logic [2:0]       res_fault_q;
    logic [PA_W-1:0]  res_pa_q;

    logic             accept, range_bad, hit, cache_load;
    logic [PA_W-1:0]  c_base;
    logic [LIM_W-1:0] c_limit;
    perm_t            c_perm, rd_perm;
    logic [2:0]       chk_fault;
    logic [PA_W-1:0]  chk_pa;
    logic [MA_W-1:0]  entry_addr;

    assign accept     = req_valid && (state_q == ST_IDLE);
    assign range_bad  = {1'b0, req_seg} >= tbl_len;
    assign cache_load = (state_q == ST_RD_LIM) && mem_rvalid;
    assign rd_perm    = mem_rdata[FLAG_MSB -: 4];
    assign entry_addr = tbl_q + MA_W'({seg_q, 1'b0});

    seg_entry_cache #(
        .SEG_W(SEG_W), .PA_W(PA_W), .LIM_W(LIM_W), .MA_W(MA_W)
    ) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cache_load),
        .load_seg   (seg_q),
        .load_tbl   (tbl_q),
        .load_base  (base_q),
        .load_limit (mem_rdata[LIM_W-1:0]),
        .load_perm  (rd_perm),
        .look_seg   (req_seg),
        .look_tbl   (tbl_base),
        .hit        (hit),
        .base       (c_base),
        .limit      (c_limit),
        .perm       (c_perm)
    );

    seg_checker #(
        .OFF_W(OFF_W), .PA_W(PA_W), .LIM_W(LIM_W)
    ) u_check (
        .base  (c_base),
        .limit (c_limit),
        .perm  (c_perm),
        .off   (off_q),
        .acc   (acc_q),
        .fault (chk_fault),
        .pa    (chk_pa)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (range_bad)  state_d = ST_RESP;
                    else if (hit)   state_d = ST_CHECK;
                    else            state_d = ST_RD_BASE;
                end
            end
            ST_RD_BASE: if (mem_rvalid) state_d = ST_RD_LIM;
            ST_RD_LIM:  if (mem_rvalid) state_d = ST_CHECK;
            ST_CHECK:   state_d = ST_RESP;
            ST_RESP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // request capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q       <= '0;
            off_q       <= '0;
            acc_q       <= '0;
            tbl_q       <= '0;
            base_q      <= '0;
            res_fault_q <= FLT_NONE;
            res_pa_q    <= '0;
        end else begin
            if (accept) begin
                seg_q <= req_seg;
                off_q <= req_off;
                acc_q <= req_acc;
                tbl_q <= tbl_base;
                if (range_bad) begin
                    res_fault_q <= FLT_RANGE;
                    res_pa_q    <= '0;
                end
            end
            if ((state_q == ST_RD_BASE) && mem_rvalid)
                base_q <= mem_rdata[PA_W-1:0];
            if (state_q == ST_CHECK) begin
                res_fault_q <= chk_fault;
                res_pa_q    <= (chk_fault == FLT_NONE) ? chk_pa : '0;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        mem_req   = 1'b0;
        mem_addr  = '0;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_RD_BASE: begin mem_req = 1'b1; mem_addr = entry_addr; end
            ST_RD_LIM:  begin mem_req = 1'b1; mem_addr = entry_addr + MA_W'(1); end
            ST_CHECK:   ;
            ST_RESP:    done = 1'b1;
            default:    ;
        endcase
    end

    assign pa    = res_pa_q;
    assign fault = res_fault_q;

endmodule

// File: rtl/seg_xlate_sva.sv
module seg_xlate_sva #(
    parameter int SEG_W = 4,
    parameter int PA_W  = 20,
    parameter int MA_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEG_W:0]   tbl_len,
    input logic             req_valid,
    input logic             req_ready,
    input logic [SEG_W-1:0] req_seg,
    input logic             done,
    input logic [PA_W-1:0]  pa,
    input logic [2:0]       fault,
    input logic             mem_req,
    input logic [MA_W-1:0]  mem_addr,
    input logic             mem_rvalid
);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !done && !mem_req));

    p_range_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ({1'b0, req_seg} >= tbl_len))
        |=> (done && fault == 3'd1 && !mem_req));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    p_code_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault <= 3'd4));

    p_fault_pa_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 3'd0) |-> (pa == '0));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    p_no_read_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

endmodule

bind seg_xlate seg_xlate_sva #(
    .SEG_W(SEG_W), .PA_W(PA_W), .MA_W(MA_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .tbl_len    (tbl_len),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_seg    (req_seg),
    .done       (done),
    .pa         (pa),
    .fault      (fault),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;

    localparam int SEG_W = 4, OFF_W = 8, PA_W = 16, MA_W = 12, DATA_W = 32;

    logic clk = 0, rst_n = 0;
    logic [MA_W-1:0]   tbl_base = '0;
    logic [SEG_W:0]    tbl_len = '0;
    logic              req_valid = 0;
    logic              req_ready;
    logic [SEG_W-1:0]  req_seg = '0;
    logic [OFF_W-1:0]  req_off = '0;
    logic [1:0]        req_acc = '0;
    logic              done;
    logic [PA_W-1:0]   pa;
    logic [2:0]        fault;
    logic              mem_req;
    logic [MA_W-1:0]   mem_addr;
    logic              mem_rvalid = 0;
    logic [DATA_W-1:0] mem_rdata = '0;

    always #10 clk = ~clk;

    seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .MA_W(MA_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_len(tbl_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
        .req_off(req_off), .req_acc(req_acc), .done(done), .pa(pa), .fault(fault),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

    int checks = 0, errors = 0;
    logic [DATA_W-1:0] mem [256];
    int lat = 1, pend = 0, cnt = 0, rd_cnt = 0;
    int rd_addr[$];
    bit in_txn = 0;
    bit m_vld = 0;
    int m_seg = 0, m_tbl = 0;

    // behavioural memory with programmable latency
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req && !mem_rvalid && pend == 0) begin
            pend = 1; cnt = lat;
            rd_cnt++; rd_addr.push_back(int'(mem_addr));
        end else if (pend != 0) begin
            if (cnt <= 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[7:0]];
                pend = 0;
            end else cnt--;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    // per-clock comparison: result pulses only inside a transaction
    always @(negedge clk) begin
        if (rst_n && done && !in_txn) chk(1'b0, "R10", "unexpected done", 1, 0);
    end

    function automatic logic [DATA_W-1:0] mk_lim(bit v, bit r, bit w, bit x, int lim);
        logic [DATA_W-1:0] t;
        t = '0;
        t[DATA_W-1] = v; t[DATA_W-2] = r; t[DATA_W-3] = w; t[DATA_W-4] = x;
        t[OFF_W:0] = (OFF_W+1)'(lim);
        return t;
    endfunction

    task automatic put(input int tb, input int seg, input int base, input logic [DATA_W-1:0] lw);
        mem[(tb + 2*seg) % 256]     = DATA_W'(base);
        mem[(tb + 2*seg + 1) % 256] = lw;
    endtask

    task automatic xlate(input string req, input int seg, input int off, input int acc, input bit poke);
        int e_fault, e_pa, e_reads, e_lat, cyc, ea;
        logic [DATA_W-1:0] w0, w1;
        bit hit, perm;
        ea = int'(tbl_base) + 2*seg;
        e_pa = 0;
        if (seg >= int'(tbl_len)) begin
            e_fault = 1; e_reads = 0; e_lat = 1;
        end else begin
            hit = m_vld && m_seg == seg && m_tbl == int'(tbl_base);
            e_reads = hit ? 0 : 2; e_lat = hit ? 2 : -1;
            if (!hit) begin m_vld = 1; m_seg = seg; m_tbl = int'(tbl_base); end
            w0 = mem[ea % 256]; w1 = mem[(ea + 1) % 256];
            case (acc)
                0: perm = w1[DATA_W-2];
                1: perm = w1[DATA_W-3];
                2: perm = w1[DATA_W-4];
                default: perm = 0;
            endcase
            if (!w1[DATA_W-1])                  e_fault = 2;
            else if (off >= int'(w1[OFF_W:0]))  e_fault = 3;
            else if (!perm)                     e_fault = 4;
            else begin
                e_fault = 0;
                e_pa = (int'(w0[PA_W-1:0]) + off) % (1 << PA_W);
            end
        end
        @(negedge clk);
        rd_cnt = 0; rd_addr.delete();
        req_valid = 1; req_seg = SEG_W'(seg); req_off = OFF_W'(off); req_acc = 2'(acc);
        chk(req_ready == 1'b1, req, "ready before request", int'(req_ready), 1);
        in_txn = 1;
        @(negedge clk);
        cyc = 1;
        if (poke) begin
            req_seg = SEG_W'(seg + 3); req_off = '1; req_acc = 2'd3;
            chk(req_ready == 1'b0, "R10", "ready while busy", int'(req_ready), 0);
            @(negedge clk); cyc++;
        end
        req_valid = 0;
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
        chk(done == 1'b1, req, "done seen", int'(done), 1);
        chk(int'(fault) == e_fault, req, "fault", int'(fault), e_fault);
        chk(int'(pa) == e_pa, req, "pa", int'(pa), e_pa);
        chk(rd_cnt == e_reads, req, "memory reads", rd_cnt, e_reads);
        if (e_lat > 0) chk(cyc == e_lat, req, "latency", cyc, e_lat);
        if (e_reads == 2 && rd_addr.size() == 2) begin
            chk(rd_addr[0] == ea % 4096, "R3", "base word address", rd_addr[0], ea);
            chk(rd_addr[1] == (ea + 1) % 4096, "R3", "limit word address", rd_addr[1], ea + 1);
        end
        @(negedge clk);
        chk(done == 1'b0, "R10", "done is one pulse", int'(done), 0);
        in_txn = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        put(16, 0, 16'h1000, mk_lim(1, 1, 1, 1, 256));
        put(16, 1, 16'h2000, mk_lim(1, 1, 0, 0, 16'h40));
        put(16, 2, 16'h2400, mk_lim(0, 0, 0, 0, 0));
        put(16, 3, 16'hFFF0, mk_lim(1, 0, 0, 1, 16'h80));
        put(16, 4, 16'h3000, mk_lim(1, 0, 0, 0, 16'h10));
        put(16, 5, 16'h5000, mk_lim(1, 0, 1, 0, 16'h20));
        put(64, 0, 16'h3000, mk_lim(1, 1, 1, 1, 256));
        tbl_base = 12'd16; tbl_len = 5'd6;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", int'(req_ready), 1);
        chk(done == 1'b0, "R1", "reset done", int'(done), 0);
        chk(mem_req == 1'b0, "R1", "reset mem_req", int'(mem_req), 0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_req == 1'b0, "R1", "idle after reset", int'(mem_req), 0);

        lat = 1;
        xlate("R3", 0, 8'h10, 0, 0);          // miss: fetch, pa 0x1010
        xlate("R9", 0, 8'hFF, 1, 0);          // hit, last legal offset of full segment
        xlate("R8", 1, 8'h3F, 0, 0);          // pa 0x203F
        xlate("R5", 1, 8'h40, 0, 0);          // offset == limit
        xlate("R6", 1, 8'h00, 1, 0);          // write refused
        xlate("R6", 1, 8'h00, 2, 0);          // execute refused
        xlate("R6", 1, 8'h00, 3, 0);          // reserved code refused
        lat = 3;
        xlate("R4", 2, 8'h05, 1, 0);          // invalid wins over limit and privilege (R7)
        xlate("R8", 3, 8'h20, 2, 0);          // wraps to 0x0010
        xlate("R6", 3, 8'h20, 0, 0);
        xlate("R7", 4, 8'h20, 1, 0);          // limit before privilege
        xlate("R2", 6, 8'h00, 0, 0);          // first out-of-range number
        xlate("R2", 15, 8'h00, 0, 0);
        xlate("R9", 4, 8'h20, 1, 0);          // range fault left remembered entry intact
        xlate("R10", 5, 8'h1F, 1, 1);         // requests while busy ignored
        tbl_base = 12'd64;
        xlate("R9", 0, 8'h10, 0, 0);          // new table base forces fetch, pa 0x3010
        tbl_len = 5'd0;
        xlate("R11", 0, 8'h00, 0, 0);
        tbl_len = 5'd6;
        xlate("R9", 0, 8'h01, 2, 0);          // still remembered
        lat = 2;
        xlate("R3", 5, 8'h00, 1, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule